// File: doc/BRIEF.md
# Event Injection Descriptor Checker

This block decides whether a pending event-injection request is legal before a guest is entered. The request is a 32-bit information word, a 32-bit exception error code and a 32-bit instruction length. Four configuration levels qualify the checks: the unrestricted-guest enable, the guest protected-mode bit, support for the pending-trap event kind, and permission for a zero instruction length.

A one-cycle `start` pulse samples every input. One clock later the block raises `done` for a single cycle. At the same time it presents an 8-bit mask with one bit for each violated rule, and `pass`, which is high only when `done` is high and no rule is violated. The mask keeps its value until the next `start`.

Control is a two-state machine. `S_IDLE` waits for a start. `S_REPORT` is the cycle in which `done` is shown. The transitions are: `T_LAUNCH` (S_IDLE to S_REPORT on start), `T_CHAIN` (S_REPORT to S_REPORT on a back-to-back start), `T_RETIRE` (S_REPORT to S_IDLE without start) and `T_WAIT` (S_IDLE holds without start). Synchronous reset forces S_IDLE.

Information word layout: bit 31 is valid, bits 30:12 are reserved, bit 11 is deliver-error-code, bits 10:8 are the kind, and bits 7:0 are the vector. Kind codes: 0 external interrupt, 1 reserved, 2 NMI, 3 hardware exception, 4 software interrupt, 5 privileged software exception, 6 software exception, 7 other event.

Top module: `evinj_check`

## Requirements
- R1: When bit 31 of the information word is 0 at start, the reported mask is 0 and `pass` is 1 in the `done` cycle.
- R2: Mask bit 0 is set when the kind is 1, or when the kind is 7 and the pending-trap support input is 0.
- R3: Mask bit 1 is set when the kind is 2 (NMI) and the vector is not 2.
- R4: Mask bit 2 is set when the kind is 3 (hardware exception) and the vector is above 31.
- R5: Mask bit 3 is set when the kind is 7 and the vector is not 0.
- R6: Mask bit 4 is set when bit 11 differs from the required value. The required value is 1 exactly when (unrestricted-guest is 0 or protected-mode is 1), the kind is 3, and the vector is one of 8, 10, 11, 12, 13, 14, 17.
- R7: Mask bit 5 is set when any of bits 30:12 of the information word is 1.
- R8: Mask bit 6 is set when bit 11 is 1 and any of bits 31:15 of the error code is 1.
- R9: Mask bit 7 is set for kinds 4, 5 and 6 when the length exceeds 15, or when the length is 0 and the zero-length permission is 0.
- R10: `done` is 1 in exactly the cycle after each start and 0 otherwise. `pass` equals `done` AND (mask == 0).
- R11: The mask keeps its value while start is low. A synchronous reset clears the mask and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Sample request and begin a check |
| info_word | input | 32 | Injection information word |
| err_code | input | 32 | Exception error code |
| insn_len | input | 32 | Instruction length |
| unres_guest | input | 1 | Unrestricted-guest enable |
| guest_pm | input | 1 | Guest protected-mode bit |
| trap_kind_ok | input | 1 | Pending-trap event kind supported |
| zero_len_ok | input | 1 | Zero instruction length permitted |
| done | output | 1 | Result valid pulse |
| pass | output | 1 | Descriptor legal |
| viol_mask | output | 8 | Violated-rule mask |

## Verification
If the state register is wrong, `done` goes missing, gets stretched or repeats. That shows up in the first cycle after a start, or in the cycle after that. If the mask register is wrong, the mask is loaded stale or changes while start is low. The bench catches this by checking the mask both in the `done` cycle and one cycle later, after it has deliberately changed the inputs. A wrong rule term sets or drops a single mask bit on the first request that reaches it. Directed corner vectors and random kinds make sure every rule is reached.

// File: rtl/evinj_pkg.sv
package evinj_pkg;

    // Field positions in the information word
    localparam int VALID_BIT  = 31;
    localparam int ERRF_BIT   = 11;
    localparam int KIND_LSB   = 8;
    localparam int KIND_W     = 3;
    localparam int VEC_W      = 8;
    localparam int RSVD_LSB   = 12;
    localparam int RSVD_MSB   = 30;

    // Rule indices in the violation mask
    localparam int RULE_N        = 8;
    localparam int RB_KIND       = 0;
    localparam int RB_NMI_VEC    = 1;
    localparam int RB_HWX_VEC    = 2;
    localparam int RB_OTHER_VEC  = 3;
    localparam int RB_ERRF       = 4;
    localparam int RB_RSVD       = 5;
    localparam int RB_ERR_HIGH   = 6;
    localparam int RB_LEN        = 7;

    typedef enum logic [KIND_W-1:0] {
        EK_EXT   = 3'd0,
        EK_RSVD  = 3'd1,
        EK_NMI   = 3'd2,
        EK_HWX   = 3'd3,
        EK_SWINT = 3'd4,
        EK_PSWX  = 3'd5,
        EK_SWX   = 3'd6,
        EK_OTHER = 3'd7
    } ev_kind_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic             valid;
        logic             err_flag;
        ev_kind_e         kind;
        logic [VEC_W-1:0] vec;
        logic             rsvd_nz;
    } info_fields_t;

endpackage

// File: rtl/evinj_field_split.sv
module evinj_field_split
    import evinj_pkg::*;
#(
    parameter int INFO_W = 32
) (
    input  logic [INFO_W-1:0] info_word,
    output info_fields_t      fields
);
    localparam int RSVD_W = RSVD_MSB - RSVD_LSB + 1;

    logic [RSVD_W-1:0] rsvd_slice;

    always_comb begin
        rsvd_slice       = info_word[RSVD_MSB:RSVD_LSB];
        fields.valid     = info_word[VALID_BIT];
        fields.err_flag  = info_word[ERRF_BIT];
        fields.kind      = ev_kind_e'(info_word[KIND_LSB +: KIND_W]);
        fields.vec       = info_word[VEC_W-1:0];
        fields.rsvd_nz   = |rsvd_slice;
    end
endmodule

// File: rtl/evinj_rule_eval.sv
module evinj_rule_eval
    import evinj_pkg::*;
#(
    parameter int          ERR_W        = 32,
    parameter int          LEN_W        = 32,
    parameter int          ERR_HIGH_LSB = 15,
    parameter int          MAX_LEN      = 15,
    parameter int          NMI_VECTOR   = 2,
    parameter int          HWX_VEC_MAX  = 31,
    parameter int          SET_W        = 32,
    parameter logic [31:0] ERRC_VEC_SET = 32'h0002_7D00
) (
    input  info_fields_t       fields,
    input  logic [ERR_W-1:0]   err_code,
    input  logic [LEN_W-1:0]   insn_len,
    input  logic               unres_guest,
    input  logic               guest_pm,
    input  logic               trap_kind_ok,
    input  logic               zero_len_ok,
    output logic [RULE_N-1:0]  mask
);
    localparam int SET_IDX_W = $clog2(SET_W);

    logic [ERR_W-1:0]  err_high;
    logic [SET_W-1:0]  set_hit;
    logic              vec_in_set;
    logic              need_errf;
    logic              sw_kind;
    logic              len_bad;
    logic [RULE_N-1:0] raw;

    // One comparator per vector slot in the error-code set
    genvar gi;
    generate
        for (gi = 0; gi < SET_W; gi++) begin : g_set
            assign set_hit[gi] = ERRC_VEC_SET[gi] &&
                                 (fields.vec == VEC_W'(gi));
        end
    endgenerate

    always_comb begin
        err_high   = err_code >> ERR_HIGH_LSB;
        vec_in_set = |set_hit;
        need_errf  = (!unres_guest || guest_pm) &&
                     (fields.kind == EK_HWX) && vec_in_set;
        sw_kind    = (fields.kind == EK_SWINT) || (fields.kind == EK_PSWX) ||
                     (fields.kind == EK_SWX);
        len_bad    = (insn_len > LEN_W'(MAX_LEN)) ||
                     ((insn_len == '0) && !zero_len_ok);

        raw = '0;
        unique case (fields.kind)
            EK_RSVD:  raw[RB_KIND] = 1'b1;
            EK_OTHER: begin
                raw[RB_KIND]      = !trap_kind_ok;
                raw[RB_OTHER_VEC] = (fields.vec != '0);
            end
            EK_NMI:   raw[RB_NMI_VEC] = (fields.vec != VEC_W'(NMI_VECTOR));
            EK_HWX:   raw[RB_HWX_VEC] = (fields.vec > VEC_W'(HWX_VEC_MAX));
            EK_EXT, EK_SWINT, EK_PSWX, EK_SWX: ;
            default: ;
        endcase
        raw[RB_ERRF]     = (fields.err_flag != need_errf);
        raw[RB_RSVD]     = fields.rsvd_nz;
        raw[RB_ERR_HIGH] = fields.err_flag && (|err_high);
        raw[RB_LEN]      = sw_kind && len_bad;

        mask = fields.valid ? raw : '0;
    end
endmodule

// File: rtl/evinj_ctl_fsm.sv
module evinj_ctl_fsm
    import evinj_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done,
    output logic load
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    // Next-state and state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = start ? S_REPORT : S_IDLE;   // T_LAUNCH / T_WAIT
            S_REPORT: state_d = start ? S_REPORT : S_IDLE;   // T_CHAIN / T_RETIRE
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Outputs
    always_comb begin
        done = 1'b0;
        load = start;
        unique case (state_q)
            S_IDLE:   done = 1'b0;
            S_REPORT: done = 1'b1;
            default:  done = 1'b0;
        endcase
    end
endmodule

// File: rtl/evinj_check.sv
module evinj_check
    import evinj_pkg::*;
#(
    parameter int          INFO_W       = 32,
    parameter int          ERR_W        = 32,
    parameter int          LEN_W        = 32,
    parameter int          ERR_HIGH_LSB = 15,
    parameter int          MAX_LEN      = 15,
    parameter int          NMI_VECTOR   = 2,
    parameter int          HWX_VEC_MAX  = 31,
    parameter logic [31:0] ERRC_VEC_SET = 32'h0002_7D00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [INFO_W-1:0] info_word,
    input  logic [ERR_W-1:0]  err_code,
    input  logic [LEN_W-1:0]  insn_len,
    input  logic              unres_guest,
    input  logic              guest_pm,
    input  logic              trap_kind_ok,
    input  logic              zero_len_ok,
    output logic              done,
    output logic              pass,
    output logic [7:0]        viol_mask
);
    info_fields_t      fields;
    logic [RULE_N-1:0] mask_d;
    logic [RULE_N-1:0] mask_q;
    logic              load;

    evinj_field_split #(.INFO_W(INFO_W)) u_split (
        .info_word (info_word),
        .fields    (fields)
    );

    evinj_rule_eval #(
        .ERR_W        (ERR_W),
        .LEN_W        (LEN_W),
        .ERR_HIGH_LSB (ERR_HIGH_LSB),
        .MAX_LEN      (MAX_LEN),
        .NMI_VECTOR   (NMI_VECTOR),
        .HWX_VEC_MAX  (HWX_VEC_MAX),
        .SET_W        (32),
        .ERRC_VEC_SET (ERRC_VEC_SET)
    ) u_rules (
        .fields       (fields),
        .err_code     (err_code),
        .insn_len     (insn_len),
        .unres_guest  (unres_guest),
        .guest_pm     (guest_pm),
        .trap_kind_ok (trap_kind_ok),
        .zero_len_ok  (zero_len_ok),
        .mask         (mask_d)
    );

    evinj_ctl_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .done  (done),
        .load  (load)
    );

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (load) mask_q <= mask_d;
    end

    always_comb begin
        viol_mask = mask_q;
        pass      = done && (mask_q == '0);
    end
endmodule

// File: rtl/evinj_check_sva.sv
module evinj_check_sva (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] info_word,
    input logic        done,
    input logic        pass,
    input logic [7:0]  viol_mask
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done);                                              // R10
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);                                            // R10
    AST_INVALID_PASSES: assert property (@(posedge clk) disable iff (rst)
        (start && !info_word[31]) |=> (pass && viol_mask == 8'h00));  // R1
    AST_TYPE_ONE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (start && info_word[31] && info_word[10:8] == 3'd1) |=> viol_mask[0]); // R2
    AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (start && info_word[31] && |info_word[30:12]) |=> viol_mask[5]); // R7
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(viol_mask));                               // R11
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (viol_mask == 8'h00 && !done));                       // R11
endmodule

bind evinj_check evinj_check_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .info_word (info_word),
    .done      (done),
    .pass      (pass),
    .viol_mask (viol_mask)
);

// File: tb/test_evinj_check.sv
module test_evinj_check;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] info_word, err_code, insn_len;
    logic        unres_guest, guest_pm, trap_kind_ok, zero_len_ok;
    logic        done, pass;
    logic [7:0]  viol_mask;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evinj_check i_evinj_check (
        .clk(clk), .rst(rst), .start(start), .info_word(info_word),
        .err_code(err_code), .insn_len(insn_len), .unres_guest(unres_guest),
        .guest_pm(guest_pm), .trap_kind_ok(trap_kind_ok),
        .zero_len_ok(zero_len_ok), .done(done), .pass(pass),
        .viol_mask(viol_mask)
    );

    function automatic logic [7:0] ref_mask(
        input logic [31:0] iw, input logic [31:0] ec, input logic [31:0] ln,
        input logic ug, input logic pm, input logic tk, input logic zk);
        logic [7:0] m;
        logic [2:0] k;
        logic [7:0] v;
        logic need;
        m = '0;
        k = iw[10:8];
        v = iw[7:0];
        if (!iw[31]) return 8'h00;                                // R1
        if (k == 3'd1 || (k == 3'd7 && !tk)) m[0] = 1'b1;         // R2
        if (k == 3'd2 && v != 8'd2) m[1] = 1'b1;                  // R3
        if (k == 3'd3 && v > 8'd31) m[2] = 1'b1;                  // R4
        if (k == 3'd7 && v != 8'd0) m[3] = 1'b1;                  // R5
        need = (!ug || pm) && (k == 3'd3) &&
               (v == 8 || v == 10 || v == 11 || v == 12 || v == 13 ||
                v == 14 || v == 17);
        if (iw[11] != need) m[4] = 1'b1;                          // R6
        if (iw[30:12] != 19'd0) m[5] = 1'b1;                      // R7
        if (iw[11] && ec[31:15] != 17'd0) m[6] = 1'b1;            // R8
        if ((k == 3'd4 || k == 3'd5 || k == 3'd6) &&
            (ln > 32'd15 || (ln == 32'd0 && !zk))) m[7] = 1'b1;   // R9
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // Issue one request, check the done cycle and the following hold cycle
    task automatic run_one(input string req, input logic [31:0] iw,
                           input logic [31:0] ec, input logic [31:0] ln,
                           input logic ug, input logic pm, input logic tk,
                           input logic zk);
        logic [7:0] exp;
        exp = ref_mask(iw, ec, ln, ug, pm, tk, zk);
        info_word = iw; err_code = ec; insn_len = ln;
        unres_guest = ug; guest_pm = pm; trap_kind_ok = tk; zero_len_ok = zk;
        start = 1'b1;
        @(negedge clk);
        check({req, " mask"}, 32'(viol_mask), 32'(exp));
        check("R10 done", 32'(done), 32'd1);
        check("R10 pass", 32'(pass), 32'(exp == 8'h00));
        start = 1'b0;
        info_word = $urandom;
        err_code  = $urandom;
        insn_len  = $urandom;
        @(negedge clk);
        check("R10 done low", 32'(done), 32'd0);
        check("R10 pass low", 32'(pass), 32'd0);
        check("R11 hold", 32'(viol_mask), 32'(exp));
    endtask

    function automatic logic [7:0] pick_vec();
        logic [7:0] list [13] = '{8'd0, 8'd2, 8'd8, 8'd9, 8'd10, 8'd11, 8'd12,
                                  8'd13, 8'd14, 8'd17, 8'd31, 8'd32, 8'd255};
        if ($urandom % 3 != 0) return list[$urandom % 13];
        return 8'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; start = 1'b0;
        info_word = '0; err_code = '0; insn_len = '0;
        unres_guest = 0; guest_pm = 0; trap_kind_ok = 0; zero_len_ok = 0;
        repeat (3) @(negedge clk);
        check("R11 reset mask", 32'(viol_mask), 32'd0);
        check("R11 reset done", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corners
        run_one("R1",  32'h0000_0FFF, 32'hFFFF_FFFF, 32'd99, 0, 0, 0, 0);
        run_one("R2",  32'h8000_0100, 32'd0, 32'd1, 0, 0, 1, 1);
        run_one("R2",  32'h8000_0700, 32'd0, 32'd1, 0, 0, 0, 1);
        run_one("R5",  32'h8000_0700, 32'd0, 32'd1, 0, 0, 1, 1);
        run_one("R5",  32'h8000_0701, 32'd0, 32'd1, 0, 0, 1, 1);
        run_one("R3",  32'h8000_0202, 32'd0, 32'd1, 0, 0, 0, 0);
        run_one("R3",  32'h8000_0203, 32'd0, 32'd1, 0, 0, 0, 0);
        run_one("R4",  32'h8000_031F, 32'd0, 32'd1, 0, 0, 0, 0);
        run_one("R4",  32'h8000_0320, 32'd0, 32'd1, 0, 0, 0, 0);
        run_one("R6",  32'h8000_0B0E, 32'h0000_7FFF, 32'd1, 0, 0, 0, 0);
        run_one("R6",  32'h8000_0B0E, 32'd0, 32'd1, 1, 0, 0, 0);
        run_one("R6",  32'h8000_030E, 32'd0, 32'd1, 1, 0, 0, 0);
        run_one("R6",  32'h8000_0B11, 32'd0, 32'd1, 1, 1, 0, 0);
        run_one("R6",  32'h8000_0B09, 32'd0, 32'd1, 0, 0, 0, 0);
        run_one("R8",  32'h8000_0B0D, 32'h0000_8000, 32'd1, 0, 0, 0, 0);
        run_one("R7",  32'h8000_1000, 32'd0, 32'd1, 0, 0, 0, 0);
        run_one("R7",  32'hC000_0000, 32'd0, 32'd1, 0, 0, 0, 0);
        run_one("R9",  32'h8000_0400, 32'd0, 32'd15, 0, 0, 0, 0);
        run_one("R9",  32'h8000_0500, 32'd0, 32'd16, 0, 0, 0, 0);
        run_one("R9",  32'h8000_0600, 32'd0, 32'd0, 0, 0, 0, 0);
        run_one("R9",  32'h8000_0600, 32'd0, 32'd0, 0, 0, 0, 1);
        run_one("R9",  32'h8000_0000, 32'd0, 32'd0, 0, 0, 0, 0);

        // Back-to-back starts keep done high (R10)
        info_word = 32'h8000_0100; start = 1'b1;
        @(negedge clk);
        info_word = 32'h8000_0000;
        @(negedge clk);
        check("R10 chained done", 32'(done), 32'd1);
        check("R10 chained mask", 32'(viol_mask), 32'(ref_mask(32'h8000_0000,
              err_code, insn_len, unres_guest, guest_pm, trap_kind_ok, zero_len_ok)));
        start = 1'b0;
        @(negedge clk);

        // Constrained random
        for (int i = 0; i < 600; i++) begin
            logic [31:0] iw, ec, ln;
            iw = '0;
            iw[31]    = ($urandom % 8) != 0;
            iw[10:8]  = 3'($urandom);
            iw[7:0]   = pick_vec();
            iw[11]    = 1'($urandom);
            if ($urandom % 8 == 0) iw[30:12] = 19'($urandom);
            ec = ($urandom % 2) ? 32'($urandom % 32768) : $urandom;
            case ($urandom % 5)
                0: ln = 32'd0;
                1: ln = 32'd1;
                2: ln = 32'd15;
                3: ln = 32'd16;
                default: ln = $urandom;
            endcase
            run_one("R1-mix", iw, ec, ln, 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
        end

        // Reset mid-result clears state (R11)
        run_one("R2", 32'h8000_0100, 32'd0, 32'd1, 0, 0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        check("R11 reset clears", 32'(viol_mask), 32'd0);
        rst = 1'b0;
        finish_run();
    end
endmodule